// File: doc/BRIEF.md
# Directory Home-Node Coherence Controller

This block is the home node for part of the memory in a distributed shared-memory machine with a small, fixed number of nodes. It stores a small array of data blocks. Beside each block it keeps a directory entry. The entry holds a state (Uncached, Shared or Exclusive) and a presence vector with one bit per node. Remote cache controllers send it read-miss, write-miss and writeback requests. The controller keeps one writer or many readers per block. When a node writes, it sends invalidations to every other holder. When a node reads a block that another node owns, it fetches the data back from the owner. It replies with data once the protocol work is done.

The controller handles one transaction at a time. Requests enter on a valid/ready port. Outgoing messages (invalidate, fetch, shared-data reply, exclusive-data reply) leave on a second valid/ready port. Remote answers (invalidation acknowledgements and fetched data) arrive on a third port that has no ready signal. Invalidations go out back-to-back, lowest node first, without waiting for any acknowledgement. A counter tracks how many acknowledgements are still due.

The state machine has seven states:
- IDLE accepts a request and moves to DECIDE.
- DECIDE reads the directory entry and goes to one of four states:
  - INV_SEND for a write while other holders exist.
  - FETCH_SEND for a read of a block that another node owns.
  - REPLY otherwise.
  - IDLE for a writeback.
- INV_SEND sends the invalidations. It moves to INV_WAIT after the last one is accepted.
- INV_WAIT moves to REPLY when the acknowledgement count reaches zero.
- FETCH_SEND moves to FETCH_WAIT once the fetch is accepted.
- FETCH_WAIT moves to REPLY when the owner's data arrives.
- REPLY sends the data reply, updates the directory as the reply is accepted, and returns to IDLE.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every directory entry is Uncached with an empty presence vector, every data block reads as zero, `req_ready` is 1 and `msg_valid` is 0.
- R2: A read of an Uncached or Shared block produces one shared-data reply (`msg_kind` 2) to the requester, carrying the stored block. The block becomes Shared with the requester's presence bit added.
- R3: A write produces one invalidation (`msg_kind` 0) for each node whose presence bit is set, except the requester. Each such node gets exactly one, in ascending node order, sent on consecutive accepted cycles.
- R4: A write's exclusive-data reply (`msg_kind` 3) leaves only after every invalidation has been acknowledged (`rsp_kind` 0). The requester then becomes the sole owner (Exclusive, exactly one presence bit).
- R5: A write by a node that is the only holder, or by a block with no holders, gets its exclusive-data reply with no invalidation.
- R6: A read of a block that another node owns sends a fetch (`msg_kind` 1) to the owner. The fetched data (`rsp_kind` 1 from the owner) is stored, then returned in a shared-data reply. Owner and requester both become sharers.
- R7: When the block was Exclusive, the owner's invalidation acknowledgement carries its data. The controller stores that data and forwards it in the exclusive-data reply.
- R8: A writeback (`req_kind` 2) from the owner stores its data and returns the block to Uncached with an empty presence vector. No message is sent.
- R9: A writeback from a node that is not the Exclusive owner sends no message and changes neither the data nor the directory entry.
- R10: `req_ready` is low from the cycle after a request is accepted until the final reply is accepted. A writeback is busy for exactly one cycle.
- R11: While `msg_valid` is high and `msg_ready` is low, the message and its fields stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and taking a request |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 writeback |
| req_node | input | log2(NODES) | Requesting node |
| req_addr | input | log2(BLOCKS) | Block index |
| req_data | input | DATA_W | Writeback data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 invalidate, 1 fetch, 2 shared-data reply, 3 exclusive-data reply |
| msg_node | output | log2(NODES) | Destination node |
| msg_addr | output | log2(BLOCKS) | Block index |
| msg_data | output | DATA_W | Block data on replies, zero otherwise |
| rsp_valid | input | 1 | Remote answer present (single cycle) |
| rsp_kind | input | 1 | 0 invalidation ack, 1 fetched data |
| rsp_node | input | log2(NODES) | Answering node |
| rsp_data | input | DATA_W | Data carried by the answer |

## Verification
The bench drives the controller with several directory situations:
- cold reads;
- reads that pile up sharers;
- writes that meet zero, one or three other holders;
- reads of a block that another node owns;
- owner and stale writebacks.

Each of these separates one path through the state machine. For example, a write by the sole sharer must not emit any invalidation, while a write by a fourth node must emit exactly three, in order. Remote acknowledgements and fetched data come back after random delays. Outgoing ready is throttled at random, so early replies and fields that move while stalled both show up. A long run of seeded random requests follows, with every reply checked against a bench-side model of the directory and memory.

// File: rtl/dhc_pkg.sv
package dhc_pkg;

    typedef enum logic [1:0] {
        DIR_UNC = 2'd0,
        DIR_SHD = 2'd1,
        DIR_EXC = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_INV_SEND,
        ST_INV_WAIT,
        ST_FETCH_SEND,
        ST_FETCH_WAIT,
        ST_REPLY
    } fsm_e;

    localparam logic [1:0] REQ_READ  = 2'd0;
    localparam logic [1:0] REQ_WRITE = 2'd1;
    localparam logic [1:0] REQ_WBACK = 2'd2;

    localparam logic [1:0] MSG_INV   = 2'd0;
    localparam logic [1:0] MSG_FETCH = 2'd1;
    localparam logic [1:0] MSG_DSH   = 2'd2;
    localparam logic [1:0] MSG_DEX   = 2'd3;

    localparam logic RSP_ACK  = 1'b0;
    localparam logic RSP_DATA = 1'b1;

endpackage

// File: rtl/dhc_lowbit.sv
module dhc_lowbit #(
    parameter int W = 4
) (
    input  logic [W-1:0]         vec,
    output logic [$clog2(W)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(W);

    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/dhc_store.sv
module dhc_store
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [$clog2(BLOCKS)-1:0] addr,
    output dir_state_e                rd_state,
    output logic [NODES-1:0]          rd_pres,
    output logic [DATA_W-1:0]         rd_data,
    input  logic                      dir_we,
    input  dir_state_e                dir_state_in,
    input  logic [NODES-1:0]          dir_pres_in,
    input  logic                      mem_we,
    input  logic [DATA_W-1:0]         mem_in
);
    logic [BLOCKS-1:0][1:0]        st_all;
    logic [BLOCKS-1:0][NODES-1:0]  pres_all;
    logic [BLOCKS-1:0][DATA_W-1:0] mem_all;

    for (genvar b = 0; b < BLOCKS; b++) begin : g_blk
        dir_state_e        st_q;
        logic [NODES-1:0]  pres_q;
        logic [DATA_W-1:0] mem_q;
        logic              hit;

        assign hit = (int'(addr) == b);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q   <= DIR_UNC;
                pres_q <= '0;
                mem_q  <= '0;
            end else if (hit) begin
                if (dir_we) begin
                    st_q   <= dir_state_in;
                    pres_q <= dir_pres_in;
                end
                if (mem_we) begin
                    mem_q <= mem_in;
                end
            end
        end

        assign st_all[b]   = st_q;
        assign pres_all[b] = pres_q;
        assign mem_all[b]  = mem_q;
    end

    assign rd_state = dir_state_e'(st_all[addr]);
    assign rd_pres  = pres_all[addr];
    assign rd_data  = mem_all[addr];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [1:0]                req_kind,
    input  logic [$clog2(NODES)-1:0]  req_node,
    input  logic [$clog2(BLOCKS)-1:0] req_addr,
    input  logic [DATA_W-1:0]         req_data,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [1:0]                msg_kind,
    output logic [$clog2(NODES)-1:0]  msg_node,
    output logic [$clog2(BLOCKS)-1:0] msg_addr,
    output logic [DATA_W-1:0]         msg_data,
    input  logic                      rsp_valid,
    input  logic                      rsp_kind,
    input  logic [$clog2(NODES)-1:0]  rsp_node,
    input  logic [DATA_W-1:0]         rsp_data
);
    localparam int NW = $clog2(NODES);
    localparam int AW = $clog2(BLOCKS);
    localparam int CW = NW + 1;

    fsm_e              state, state_nx;
    logic [1:0]        lat_kind;
    logic [NW-1:0]     lat_node;
    logic [AW-1:0]     lat_addr;
    logic [DATA_W-1:0] lat_data;
    logic [NODES-1:0]  pend;
    logic [CW-1:0]     acks_left;
    logic              was_exc;

    dir_state_e        cur_state;
    logic [NODES-1:0]  cur_pres;
    logic [DATA_W-1:0] cur_data;
    logic              dir_we, mem_we;
    dir_state_e        dir_state_in;
    logic [NODES-1:0]  dir_pres_in;
    logic [DATA_W-1:0] mem_in;

    logic [NODES-1:0]  req_bit, others;
    logic [NW-1:0]     owner, pick;
    logic              owner_any, pick_any;
    logic              ack_hit, fetch_hit, owner_wb;

    dhc_store #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .addr(lat_addr),
        .rd_state(cur_state), .rd_pres(cur_pres), .rd_data(cur_data),
        .dir_we(dir_we), .dir_state_in(dir_state_in), .dir_pres_in(dir_pres_in),
        .mem_we(mem_we), .mem_in(mem_in)
    );

    dhc_lowbit #(.W(NODES)) u_owner (.vec(cur_pres), .idx(owner), .any(owner_any));
    dhc_lowbit #(.W(NODES)) u_pick  (.vec(pend),     .idx(pick),  .any(pick_any));

    assign req_bit   = NODES'(1) << lat_node;
    assign others    = cur_pres & ~req_bit;
    assign ack_hit   = rsp_valid && (rsp_kind == RSP_ACK) && (acks_left != '0)
                       && (state == ST_INV_SEND || state == ST_INV_WAIT);
    assign fetch_hit = rsp_valid && (rsp_kind == RSP_DATA) && (state == ST_FETCH_WAIT)
                       && (rsp_node == owner);
    assign owner_wb  = (cur_state == DIR_EXC) && owner_any && (owner == lat_node);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (req_valid) state_nx = ST_DECIDE;
            ST_DECIDE: begin
                if (lat_kind == REQ_READ)
                    state_nx = (cur_state == DIR_EXC && owner != lat_node) ? ST_FETCH_SEND : ST_REPLY;
                else if (lat_kind == REQ_WRITE)
                    state_nx = (others != '0) ? ST_INV_SEND : ST_REPLY;
                else
                    state_nx = ST_IDLE;
            end
            ST_INV_SEND:   if (msg_ready && ((pend & ~(NODES'(1) << pick)) == '0)) state_nx = ST_INV_WAIT;
            ST_INV_WAIT:   if (acks_left == '0) state_nx = ST_REPLY;
            ST_FETCH_SEND: if (msg_ready) state_nx = ST_FETCH_WAIT;
            ST_FETCH_WAIT: if (fetch_hit) state_nx = ST_REPLY;
            ST_REPLY:      if (msg_ready) state_nx = ST_IDLE;
            default:       state_nx = ST_IDLE;
        endcase
    end

    // transaction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_kind  <= REQ_READ;
            lat_node  <= '0;
            lat_addr  <= '0;
            lat_data  <= '0;
            pend      <= '0;
            acks_left <= '0;
            was_exc   <= 1'b0;
        end else begin
            if (state == ST_IDLE && req_valid) begin
                lat_kind <= req_kind;
                lat_node <= req_node;
                lat_addr <= req_addr;
                lat_data <= req_data;
            end
            if (state == ST_DECIDE && lat_kind == REQ_WRITE) begin
                pend      <= others;
                acks_left <= CW'($countones(others));
                was_exc   <= (cur_state == DIR_EXC);
            end else begin
                if (state == ST_INV_SEND && msg_ready && pick_any)
                    pend <= pend & ~(NODES'(1) << pick);
                if (ack_hit)
                    acks_left <= acks_left - CW'(1);
            end
        end
    end

    // outputs and store controls
    always_comb begin
        req_ready    = (state == ST_IDLE);
        msg_valid    = 1'b0;
        msg_kind     = MSG_INV;
        msg_node     = lat_node;
        msg_addr     = lat_addr;
        msg_data     = '0;
        dir_we       = 1'b0;
        dir_state_in = cur_state;
        dir_pres_in  = cur_pres;
        mem_we       = 1'b0;
        mem_in       = rsp_data;
        unique case (state)
            ST_DECIDE: begin
                if (lat_kind == REQ_WBACK && owner_wb) begin
                    mem_we       = 1'b1;
                    mem_in       = lat_data;
                    dir_we       = 1'b1;
                    dir_state_in = DIR_UNC;
                    dir_pres_in  = '0;
                end
            end
            ST_INV_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_INV;
                msg_node  = pick;
                mem_we    = ack_hit && was_exc;
            end
            ST_INV_WAIT:   mem_we = ack_hit && was_exc;
            ST_FETCH_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = MSG_FETCH;
                msg_node  = owner;
            end
            ST_FETCH_WAIT: mem_we = fetch_hit;
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_kind  = (lat_kind == REQ_WRITE) ? MSG_DEX : MSG_DSH;
                msg_data  = cur_data;
                if (msg_ready) begin
                    if (lat_kind == REQ_WRITE) begin
                        dir_we       = 1'b1;
                        dir_state_in = DIR_EXC;
                        dir_pres_in  = req_bit;
                    end else if (!owner_wb) begin
                        dir_we       = 1'b1;
                        dir_state_in = DIR_SHD;
                        dir_pres_in  = cur_pres | req_bit;
                    end
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk
    import dhc_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int BLOCKS = 8,
    parameter int DATA_W = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      req_valid,
    input logic                      req_ready,
    input logic                      msg_valid,
    input logic                      msg_ready,
    input logic [1:0]                msg_kind,
    input logic [$clog2(NODES)-1:0]  msg_node,
    input logic [$clog2(BLOCKS)-1:0] msg_addr,
    input logic [DATA_W-1:0]         msg_data,
    input dir_state_e                cur_state,
    input logic [NODES-1:0]          cur_pres,
    input logic [$clog2(NODES):0]    acks_left
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_kind) && $stable(msg_node)
                                    && $stable(msg_addr) && $stable(msg_data));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    p_sole_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == DIR_EXC |-> $countones(cur_pres) == 1);

    p_acks_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_kind == MSG_DEX |-> acks_left == '0);

    p_uncached_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_state == DIR_UNC |-> cur_pres == '0);

    p_reply_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !msg_valid);
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
    .msg_node(msg_node), .msg_addr(msg_addr), .msg_data(msg_data),
    .cur_state(cur_state), .cur_pres(cur_pres), .acks_left(acks_left)
);

// File: tb/dir_home_ctrl_bench.sv
module dir_home_ctrl_bench;
    localparam int NODES  = 4;
    localparam int BLOCKS = 8;
    localparam int DATA_W = 16;
    localparam int NW     = 2;
    localparam int AW     = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [1:0]        req_kind = '0;
    logic [NW-1:0]     req_node = '0;
    logic [AW-1:0]     req_addr = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              msg_valid;
    logic              msg_ready = 1'b0;
    logic [1:0]        msg_kind;
    logic [NW-1:0]     msg_node;
    logic [AW-1:0]     msg_addr;
    logic [DATA_W-1:0] msg_data;
    logic              rsp_valid = 1'b0;
    logic              rsp_kind = 1'b0;
    logic [NW-1:0]     rsp_node = '0;
    logic [DATA_W-1:0] rsp_data = '0;

    always #5 clk = ~clk;

    dir_home_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS), .DATA_W(DATA_W)) u_dir_home_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_node(req_node), .req_addr(req_addr), .req_data(req_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_node(msg_node), .msg_addr(msg_addr), .msg_data(msg_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_node(rsp_node), .rsp_data(rsp_data)
    );

    int checks = 0;
    int fails  = 0;

    // model: 0 uncached, 1 shared, 2 exclusive
    int                m_state [BLOCKS];
    logic [NODES-1:0]  m_pres  [BLOCKS];
    logic [DATA_W-1:0] m_mem   [BLOCKS];
    logic [DATA_W-1:0] node_val[NODES];

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int low_idx(input logic [NODES-1:0] v);
        for (int i = 0; i < NODES; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic txn(input int kind, input int node, input int addr,
                       input logic [DATA_W-1:0] wdata, input string tag);
        logic [NODES-1:0]  nbit = NODES'(1) << node;
        logic [NODES-1:0]  exp_inv = '0;
        int                exp_fetch = -1;
        int                exp_kind = -1;
        logic [DATA_W-1:0] exp_data = '0;
        logic [DATA_W-1:0] own_val;
        int                owner = (m_state[addr] == 2) ? low_idx(m_pres[addr]) : -1;
        logic [NODES-1:0]  seen = '0, owed = '0;
        int                acks_done = 0;
        bit                fetch_owed = 0, done = 0, busy_ok = 1, held = 0;
        logic [1:0]        h_kind;
        logic [NW-1:0]     h_node;
        logic [DATA_W-1:0] h_data;
        own_val = (owner >= 0) ? node_val[owner] : '0;
        if (kind == 0) begin
            if (owner >= 0 && owner != node) begin
                exp_fetch = owner;
                m_mem[addr] = own_val;
            end
            if (!(owner >= 0 && owner == node)) begin
                m_state[addr] = 1;
                m_pres[addr] = m_pres[addr] | nbit;
            end
            exp_kind = 2;
            exp_data = m_mem[addr];
        end else if (kind == 1) begin
            exp_inv = m_pres[addr] & ~nbit;
            if (owner >= 0 && owner != node) m_mem[addr] = own_val;
            exp_kind = 3;
            exp_data = m_mem[addr];
            m_state[addr] = 2;
            m_pres[addr] = nbit;
            node_val[node] = DATA_W'($urandom);
        end else begin
            if (owner == node) begin
                m_mem[addr] = wdata;
                m_state[addr] = 0;
                m_pres[addr] = '0;
            end
        end

        @(negedge clk);
        chk(req_ready == 1'b1, {tag, "/R10"}, "idle before request", req_ready, 1);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_node  = NW'(node);
        req_addr  = AW'(addr);
        req_data  = wdata;
        @(negedge clk);
        req_valid = 1'b0;

        if (kind == 2) begin
            chk(!req_ready && !msg_valid, {tag, "/R10"}, "writeback busy one cycle",
                {req_ready, msg_valid}, 0);
            @(negedge clk);
            chk(req_ready && !msg_valid, {tag, "/R9"}, "writeback sends nothing",
                {req_ready, msg_valid}, 2);
            return;
        end

        for (int cyc = 0; cyc < 400 && !done; cyc++) begin
            rsp_valid = 1'b0;
            if (owed != '0 && $urandom_range(1, 0) == 1) begin
                int a = low_idx(owed);
                owed[a] = 1'b0;
                rsp_valid = 1'b1;
                rsp_kind  = 1'b0;
                rsp_node  = NW'(a);
                rsp_data  = (a == owner) ? own_val : DATA_W'($urandom);
                acks_done++;
            end else if (fetch_owed && $urandom_range(1, 0) == 1) begin
                fetch_owed = 0;
                rsp_valid = 1'b1;
                rsp_kind  = 1'b1;
                rsp_node  = NW'(exp_fetch);
                rsp_data  = own_val;
            end
            if (req_ready) busy_ok = 0;
            if (held) begin
                chk(msg_valid && msg_kind == h_kind && msg_node == h_node && msg_data == h_data,
                    {tag, "/R11"}, "stalled message held", {msg_kind, msg_node}, {h_kind, h_node});
            end
            msg_ready = ($urandom_range(3, 0) != 0);
            held = msg_valid && !msg_ready;
            h_kind = msg_kind; h_node = msg_node; h_data = msg_data;
            if (msg_valid && msg_ready) begin
                if (msg_kind == 2'd0) begin
                    int want = low_idx(exp_inv & ~seen);
                    chk(want >= 0 && int'(msg_node) == want, {tag, "/R3"}, "invalidate target",
                        msg_node, want);
                    if (want >= 0) begin seen[want] = 1'b1; owed[want] = 1'b1; end
                end else if (msg_kind == 2'd1) begin
                    chk(int'(msg_node) == exp_fetch, {tag, "/R6"}, "fetch target", msg_node, exp_fetch);
                    fetch_owed = (exp_fetch >= 0);
                end else begin
                    chk(int'(msg_kind) == exp_kind && int'(msg_node) == node && int'(msg_addr) == addr,
                        {tag, exp_kind == 3 ? "/R4" : "/R2"}, "reply kind/node",
                        {msg_kind, msg_node}, {2'(exp_kind), NW'(node)});
                    chk(msg_data == exp_data, {tag, exp_kind == 3 ? "/R7" : "/R2"}, "reply data",
                        msg_data, exp_data);
                    if (exp_kind == 3)
                        chk(seen == exp_inv && acks_done == $countones(exp_inv), {tag, "/R4"},
                            "acks counted before reply", acks_done, $countones(exp_inv));
                    if (exp_fetch >= 0)
                        chk(!fetch_owed, {tag, "/R6"}, "fetched data before reply", fetch_owed, 0);
                    done = 1;
                end
            end
            @(negedge clk);
        end
        rsp_valid = 1'b0;
        msg_ready = 1'b0;
        chk(done, {tag, "/R10"}, "transaction completed", done, 1);
        chk(busy_ok, {tag, "/R10"}, "busy while pending", busy_ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < BLOCKS; b++) begin
            m_state[b] = 0; m_pres[b] = '0; m_mem[b] = '0;
        end
        for (int n = 0; n < NODES; n++) node_val[n] = DATA_W'(16'h1000 + n);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && msg_valid == 1'b0, "R1", "reset outputs",
            {req_ready, msg_valid}, 2);

        txn(0, 0, 0, '0, "R1");          // cold read returns zero
        txn(0, 1, 0, '0, "R2");
        txn(0, 2, 0, '0, "R2");
        txn(1, 3, 0, '0, "R3");          // three invalidations
        txn(0, 1, 0, '0, "R6");          // fetch from owner 3
        txn(1, 0, 0, '0, "R3");          // invalidate 1 and 3
        txn(1, 0, 0, '0, "R5");          // owner rewrites
        txn(0, 2, 1, '0, "R2");
        txn(1, 2, 1, '0, "R5");          // sole sharer upgrade
        txn(1, 3, 1, '0, "R7");          // owner ack carries data
        txn(2, 1, 1, 16'hdead, "R9");    // stale writeback
        txn(0, 0, 1, '0, "R9");          // still fetched from 3
        txn(1, 3, 2, '0, "R5");
        txn(2, 0, 2, 16'h5a5a, "R9");
        txn(2, 3, 2, 16'hbeef, "R8");    // owner writeback
        txn(0, 1, 2, '0, "R8");          // returns beef, no fetch
        txn(1, 0, 2, '0, "R8");          // only node 1 invalidated

        for (int i = 0; i < 400; i++) begin
            int k = $urandom_range(2, 0);
            int n = $urandom_range(NODES - 1, 0);
            int a = $urandom_range(BLOCKS - 1, 0);
            logic [DATA_W-1:0] d = (m_state[a] == 2 && low_idx(m_pres[a]) == n)
                                   ? node_val[n] : DATA_W'($urandom);
            txn(k, n, a, d, "RND");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule